// File: doc/BRIEF.md
# Trace Message Byte Serializer

This block turns one instruction-trace message descriptor into a stream of bytes. Each byte carries six data bits in its upper part and a two-bit framing code in its lower part. The framing code tells a downstream decoder where each field ends and where the message ends. The block can build four message kinds:

- program-trace synchronisation
- direct branch
- indirect branch
- trace correlation

Most fields have variable length. Such a field is cut into 6-bit chunks, least significant chunk first, and leading zero chunks are dropped. For three of the four kinds, a small fixed code and the low bits of the first variable field are packed together into the second byte.

The producer offers a descriptor with a valid/ready handshake. The consumer takes bytes through a second valid/ready handshake, one byte per cycle when it is always ready. A new descriptor is taken only after the previous message has fully left the block. The block does not choose which messages to send, and it does not buffer or transport the bytes.

Top module: `trc_msg_serializer`

## Requirements
- R1: Every output byte has its data in bits 7:2 and its framing code in bits 1:0. The framing codes are 00 for a continuing byte, 01 for the last byte of a field that is not the final field, and 11 for the last byte of the message. Code 10 is never emitted.
- R2: The first byte of each message is the message code in bits 7:2 with framing 00. The kind input selects the code: kind 0 is sync (code 9), kind 1 is direct branch (code 3), kind 2 is indirect branch (code 4) and kind 3 is correlation (code 33).
- R3: A variable field is sent as floor(msb/6)+1 chunks of 6 bits, least significant first. A zero value is sent as one chunk of zero. The timestamp input is always the final field.
- R4: Sync message. Byte 2 holds in_code[3:0] in bits 5:2 and in_addr[1:0] in bits 7:6. Its framing is 01 if in_addr is below 4; otherwise its framing is 00 and in_addr>>2 follows as a variable field. The timestamp comes last.
- R5: Direct-branch message. The count field, as a variable field, directly follows the code byte, and the timestamp follows the count.
- R6: Indirect-branch message. Byte 2 holds in_code[1:0] in bits 3:2 and in_count[3:0] in bits 7:4. Its framing is 01 if in_count is below 16; otherwise in_count>>4 follows as a variable field. Next comes in_addr as a variable field, and the timestamp comes last.
- R7: Correlation message. Byte 2 holds in_code[3:0] in bits 5:2 and in_count[1:0] in bits 7:6. Its framing is 01 if in_count is below 4; otherwise in_count>>2 follows as a variable field. The timestamp comes last.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_byte stays unchanged.
- R9: in_ready is high only when no byte of a message is pending or waiting to be built. After a descriptor is accepted, its first byte appears two cycles later.
- R10: No message is longer than 38 bytes.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when in_valid is high |
| in_kind | input | 2 | Message kind (0 sync, 1 direct, 2 indirect, 3 correlation) |
| in_code | input | 4 | Sync code, branch type (low 2 bits) or event code |
| in_count | input | CNT_W | Instruction count field |
| in_addr | input | ADDR_W | Full address (sync) or address difference (indirect) |
| in_tstamp | input | TS_W | Timestamp field |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Data in bits 7:2, framing in bits 1:0 |

## Verification
The bench keeps its own model of the expected byte queue and checks the output on every clock. A wrong field pointer or a stale chunk register shows up at the ports straight away: a framing code at the wrong position, or a wrong data chunk. This surfaces on the first compared byte after the fault, at most one message later. A phase register stuck in its busy state shows up as in_ready staying low while the expected queue is empty, and the bench flags this on the first idle cycle. A broken hold path shows up as out_byte changing during the first cycle of back-pressure.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    K_SYNC     = 2'd0,
    K_DIRECT   = 2'd1,
    K_INDIRECT = 2'd2,
    K_CORR     = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HEAD,
    PH_PACK,
    PH_FIELD
  } phase_e;

  localparam logic [5:0] TC_SYNC     = 6'd9;
  localparam logic [5:0] TC_DIRECT   = 6'd3;
  localparam logic [5:0] TC_INDIRECT = 6'd4;
  localparam logic [5:0] TC_CORR     = 6'd33;

  localparam logic [1:0] FR_CONT = 2'b00;
  localparam logic [1:0] FR_EOF  = 2'b01;
  localparam logic [1:0] FR_EOM  = 2'b11;

  localparam int NSLOT         = 3;
  localparam int CHUNK_W       = 6;
  localparam int MAX_MSG_BYTES = 38;

endpackage

// File: rtl/trc_desc_map.sv
module trc_desc_map
  import trc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 64,
  parameter int TS_W   = 64,
  parameter int VW     = 64
) (
  input  logic [1:0]                 kind,
  input  logic [3:0]                 code,
  input  logic [CNT_W-1:0]           count,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [TS_W-1:0]            tstamp,
  output logic [5:0]                 tcode,
  output logic                       pack_en,
  output logic [7:0]                 pack_byte,
  output logic [NSLOT-1:0][VW-1:0]   slot_val,
  output logic [NSLOT-1:0]           slot_en
);

  logic [VW-1:0] cnt_x, addr_x, ts_x;
  logic [VW-1:0] addr_hi, cnt_hi4, cnt_hi2;

  assign cnt_x   = VW'(count);
  assign addr_x  = VW'(addr);
  assign ts_x    = VW'(tstamp);
  assign addr_hi = addr_x >> 2;
  assign cnt_hi4 = cnt_x >> 4;
  assign cnt_hi2 = cnt_x >> 2;

  always_comb begin
    tcode     = TC_SYNC;
    pack_en   = 1'b0;
    pack_byte = '0;
    slot_val  = '0;
    slot_en   = '0;
    case (msg_kind_e'(kind))
      K_SYNC: begin
        tcode       = TC_SYNC;
        pack_en     = 1'b1;
        pack_byte   = {addr[1:0], code[3:0], (addr_hi == '0) ? FR_EOF : FR_CONT};
        slot_val[0] = addr_hi;
        slot_en[0]  = (addr_hi != '0);
        slot_val[1] = ts_x;
        slot_en[1]  = 1'b1;
      end
      K_DIRECT: begin
        tcode       = TC_DIRECT;
        slot_val[0] = cnt_x;
        slot_en[0]  = 1'b1;
        slot_val[1] = ts_x;
        slot_en[1]  = 1'b1;
      end
      K_INDIRECT: begin
        tcode       = TC_INDIRECT;
        pack_en     = 1'b1;
        pack_byte   = {count[3:0], code[1:0], (cnt_hi4 == '0) ? FR_EOF : FR_CONT};
        slot_val[0] = cnt_hi4;
        slot_en[0]  = (cnt_hi4 != '0);
        slot_val[1] = addr_x;
        slot_en[1]  = 1'b1;
        slot_val[2] = ts_x;
        slot_en[2]  = 1'b1;
      end
      default: begin
        tcode       = TC_CORR;
        pack_en     = 1'b1;
        pack_byte   = {count[1:0], code[3:0], (cnt_hi2 == '0) ? FR_EOF : FR_CONT};
        slot_val[0] = cnt_hi2;
        slot_en[0]  = (cnt_hi2 != '0);
        slot_val[1] = ts_x;
        slot_en[1]  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/trc_chunk_slot.sv
module trc_chunk_slot #(
  parameter int VW      = 64,
  parameter int CHUNK_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [VW-1:0] load_val,
  input  logic          shift,
  output logic [VW-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (load)  value <= load_val;
    else if (shift) value <= value >> CHUNK_W;
  end

endmodule

// File: rtl/trc_msg_serializer.sv
module trc_msg_serializer
  import trc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 64,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [3:0]        in_code,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TS_W-1:0]   in_tstamp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);

  localparam int AT_W = (ADDR_W > TS_W) ? ADDR_W : TS_W;
  localparam int VW   = (AT_W > CNT_W) ? AT_W : CNT_W;
  localparam int SELW = $clog2(NSLOT);

  logic [5:0]               m_tcode;
  logic                     m_pack_en;
  logic [7:0]               m_pack_byte;
  logic [NSLOT-1:0][VW-1:0] m_slot_val;
  logic [NSLOT-1:0]         m_slot_en;

  trc_desc_map #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .VW(VW)
  ) u_map (
    .kind(in_kind), .code(in_code), .count(in_count), .addr(in_addr),
    .tstamp(in_tstamp), .tcode(m_tcode), .pack_en(m_pack_en),
    .pack_byte(m_pack_byte), .slot_val(m_slot_val), .slot_en(m_slot_en)
  );

  phase_e            phase;
  logic [SELW-1:0]   sel;
  logic [NSLOT-1:0]  slot_en_q;
  logic              pack_en_q;
  logic [7:0]        pack_byte_q;
  logic [5:0]        tcode_q;

  logic              accept, adv;
  logic [VW-1:0]     cur_val;
  logic              cur_done, cur_last;
  logic [SELW-1:0]   next_sel, first_sel;
  logic [NSLOT-1:0][VW-1:0] slot_q;
  logic [NSLOT-1:0]  slot_shift;

  assign in_ready = (phase == PH_IDLE) && !out_valid;
  assign accept   = in_valid && in_ready;
  assign adv      = !out_valid || out_ready;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_shift[g] = adv && (phase == PH_FIELD) &&
                           (sel == SELW'(g)) && !cur_done;
    trc_chunk_slot #(.VW(VW), .CHUNK_W(CHUNK_W)) u_slot (
      .clk(clk), .rst(rst), .load(accept), .load_val(m_slot_val[g]),
      .shift(slot_shift[g]), .value(slot_q[g])
    );
  end

  assign cur_val  = slot_q[sel];
  assign cur_done = (cur_val >> CHUNK_W) == '0;

  always_comb begin
    cur_last  = 1'b1;
    next_sel  = sel;
    first_sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_en_q[i]) first_sel = SELW'(i);
      if ((i > int'(sel)) && slot_en_q[i]) begin
        cur_last = 1'b0;
        next_sel = SELW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      sel         <= '0;
      slot_en_q   <= '0;
      pack_en_q   <= 1'b0;
      pack_byte_q <= '0;
      tcode_q     <= '0;
      out_valid   <= 1'b0;
      out_byte    <= '0;
    end else if (accept) begin
      phase       <= PH_HEAD;
      slot_en_q   <= m_slot_en;
      pack_en_q   <= m_pack_en;
      pack_byte_q <= m_pack_byte;
      tcode_q     <= m_tcode;
    end else if (adv) begin
      case (phase)
        PH_IDLE: out_valid <= 1'b0;
        PH_HEAD: begin
          out_byte  <= {tcode_q, FR_CONT};
          out_valid <= 1'b1;
          sel       <= first_sel;
          phase     <= pack_en_q ? PH_PACK : PH_FIELD;
        end
        PH_PACK: begin
          out_byte  <= pack_byte_q;
          out_valid <= 1'b1;
          phase     <= PH_FIELD;
        end
        default: begin
          out_valid <= 1'b1;
          if (!cur_done) begin
            out_byte <= {cur_val[CHUNK_W-1:0], FR_CONT};
          end else if (cur_last) begin
            out_byte <= {cur_val[CHUNK_W-1:0], FR_EOM};
            phase    <= PH_IDLE;
          end else begin
            out_byte <= {cur_val[CHUNK_W-1:0], FR_EOF};
            sel      <= next_sel;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/trc_msg_serializer_chk.sv
module trc_msg_serializer_chk #(
  parameter int MAX_BYTES = 38
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);

  logic       busy;
  logic [7:0] byte_cnt;
  logic       xfer, eom_xfer;

  assign xfer     = out_valid && out_ready;
  assign eom_xfer = xfer && (out_byte[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      byte_cnt <= '0;
    end else begin
      if (in_valid && in_ready) busy <= 1'b1;
      else if (eom_xfer)        busy <= 1'b0;
      if (eom_xfer)             byte_cnt <= '0;
      else if (xfer)            byte_cnt <= byte_cnt + 8'd1;
    end
  end

  assert_no_reserved_frame_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_byte[1:0] != 2'b10));

  assert_head_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 (out_valid && out_byte[1:0] == 2'b00 && out_byte[7:2] != 6'd0));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> !busy);

  assert_bytes_inside_msg_R9: assert property (@(posedge clk) disable iff (rst)
    xfer |-> busy);

  assert_idle_after_eom_R9: assert property (@(posedge clk) disable iff (rst)
    eom_xfer |=> !out_valid);

  assert_msg_length_R10: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (byte_cnt < 8'(MAX_BYTES)));

endmodule

bind trc_msg_serializer trc_msg_serializer_chk #(.MAX_BYTES(trc_pkg::MAX_MSG_BYTES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/test_trc_msg_serializer.sv
module test_trc_msg_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = '0;
  logic [3:0]  in_code = '0;
  logic [15:0] in_count = '0;
  logic [63:0] in_addr = '0;
  logic [63:0] in_tstamp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;

  always #5 clk = ~clk;

  trc_msg_serializer i_trc_msg_serializer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_code(in_code), .in_count(in_count),
    .in_addr(in_addr), .in_tstamp(in_tstamp), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  int vectors = 0;
  int errors  = 0;
  int stall_mode = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         held = 0;
  logic [7:0] held_byte;

  task automatic push_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic push_var(input logic [63:0] v, input bit last, input string tag);
    logic [5:0] c;
    do begin
      c = v[5:0];
      v = v >> 6;
      push_byte({c, (v != 0) ? 2'b00 : (last ? 2'b11 : 2'b01)}, tag);
    end while (v != 0);
  endtask

  task automatic model(input logic [1:0] k, input logic [3:0] c, input logic [15:0] n,
                       input logic [63:0] a, input logic [63:0] t);
    logic [63:0] n64;
    n64 = {48'd0, n};
    case (k)
      2'd0: begin
        push_byte({6'd9, 2'b00}, "R2");
        push_byte({a[1:0], c, ((a >> 2) == 0) ? 2'b01 : 2'b00}, "R4");
        if ((a >> 2) != 0) push_var(a >> 2, 0, "R4");
        push_var(t, 1, "R3");
      end
      2'd1: begin
        push_byte({6'd3, 2'b00}, "R2");
        push_var(n64, 0, "R5");
        push_var(t, 1, "R3");
      end
      2'd2: begin
        push_byte({6'd4, 2'b00}, "R2");
        push_byte({n[3:0], c[1:0], ((n64 >> 4) == 0) ? 2'b01 : 2'b00}, "R6");
        if ((n64 >> 4) != 0) push_var(n64 >> 4, 0, "R6");
        push_var(a, 0, "R6");
        push_var(t, 1, "R3");
      end
      default: begin
        push_byte({6'd33, 2'b00}, "R2");
        push_byte({n[1:0], c, ((n64 >> 2) == 0) ? 2'b01 : 2'b00}, "R7");
        if ((n64 >> 2) != 0) push_var(n64 >> 2, 0, "R7");
        push_var(t, 1, "R3");
      end
    endcase
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] c, input logic [15:0] n,
                      input logic [63:0] a, input logic [63:0] t);
    @(negedge clk);
    in_kind = k; in_code = c; in_count = n; in_addr = a; in_tstamp = t;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    model(k, c, n, a, t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // cycle-by-cycle comparison against the behavioural queue
  always @(negedge clk) begin
    if (!rst) begin
      bit rdy;
      vectors++;
      if (exp_q.size() == 0) begin
        if (!in_ready || out_valid) begin
          errors++;
          $display("FAIL R9 idle: in_ready=%0b out_valid=%0b expected in_ready=1 out_valid=0",
                   in_ready, out_valid);
        end
      end else if (in_ready) begin
        errors++;
        $display("FAIL R9 busy: in_ready=%0b expected 0", in_ready);
      end
      if (held && (!out_valid || out_byte != held_byte)) begin
        errors++;
        $display("FAIL R8 hold: valid=%0b byte=%02h expected valid=1 byte=%02h",
                 out_valid, out_byte, held_byte);
      end
      rdy = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      out_ready = rdy;
      held = 0;
      if (out_valid) begin
        if (!rdy) begin
          held = 1;
          held_byte = out_byte;
        end else if (exp_q.size() != 0) begin
          logic [7:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (out_byte[1:0] == 2'b10) begin
            errors++;
            $display("FAIL R1 reserved framing: got %02h expected %02h", out_byte, e);
          end else if (out_byte != e) begin
            errors++;
            $display("FAIL %s byte: got %02h expected %02h", tg, out_byte, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, pending=%0d expected 0", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: out_valid=%0b in_ready=%0b expected 0 and 1", out_valid, in_ready);
    end
    rst = 1'b0;

    // R4: packed byte ends address for addr<4; longer addresses continue
    send(2'd0, 4'd5, 16'd0, 64'd0, 64'd0);
    send(2'd0, 4'd5, 16'd0, 64'd3, 64'd7);
    send(2'd0, 4'd5, 16'd0, 64'd4, 64'd63);
    send(2'd0, 4'hF, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: count zero and full width
    send(2'd1, 4'd0, 16'd0, 64'd0, 64'd64);
    send(2'd1, 4'd0, 16'hFFFF, 64'd0, 64'd1);
    // R6: count boundaries at 15 and 16, zero address difference
    send(2'd2, 4'd3, 16'd15, 64'd0, 64'd0);
    send(2'd2, 4'd1, 16'd16, 64'h40, 64'd5);
    send(2'd2, 4'd2, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R7: count boundaries at 3 and 4
    send(2'd3, 4'd4, 16'd3, 64'd0, 64'd9);
    send(2'd3, 4'd4, 16'd4, 64'd0, 64'd4095);
    send(2'd3, 4'd4, 16'hFFFF, 64'd0, 64'd4096);

    // R8: same patterns and random ones under back-pressure
    stall_mode = 1;
    send(2'd0, 4'd5, 16'd0, 64'h1234_5678, 64'h9ABC);
    send(2'd2, 4'd2, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 80; i++) begin
      logic [63:0] a, t;
      a = {$urandom, $urandom} >> ($urandom % 64);
      t = {$urandom, $urandom} >> ($urandom % 64);
      send(2'($urandom % 4), 4'($urandom), 16'($urandom) >> ($urandom % 16), a, t);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule